// File: doc/BRIEF.md
# Memory-Mapped Text Output Port

This block sits on a simple word-wide register bus and drives a character display. It has two registers. Software reads the control register until its ready flag is set, then stores one 32-bit word into the data register. A word whose low byte is the bell code (0x07) is a cursor command. It carries a packed row and column, and the cursor moves there at once. Any other low byte is a character to draw.

When the port accepts a character, it emits a one-cycle draw strobe. The strobe carries the character code and the cursor position at which it is drawn. The cursor then moves to the next column, and the ready flag stays low for a set number of cycles while the display side is drawing. A data store that arrives while the port is busy is discarded and raises a sticky overrun flag. Software clears that flag through the control register.

The register addresses, the drawing latency and the line width are parameters. Reading the data register returns the current cursor position in the same packed layout that a cursor command uses.

Top module: `text_display_port`

## Requirements
- R1: After reset, the control register reads 0x00000001 (ready set, overrun clear), the cursor is at row 0 and column 0, and `draw_stb` is low.
- R2: A read of the control register (default address 0xFFFF0008) returns bit 0 = ready, bit 1 = overrun sticky flag, and bits 31:2 = 0.
- R3: A data-register store (default address 0xFFFF000C) while ready, with a low byte other than 0x07, raises `draw_stb` for exactly one cycle, starting on the cycle after the store edge. The strobe carries `draw_char` = bits 7:0 of the word, and `draw_row` and `draw_col` = the cursor position before the store. Bits 31:8 of the word have no effect.
- R4: After a printable character is accepted, ready reads 0 for exactly DRAW_LAT cycles after the store edge and then reads 1.
- R5: Each accepted character advances the column by one. When the incremented column would reach LINE_W or more, the column becomes 0 and the row increases by one. The row wraps from 4095 to 0.
- R6: A data-register store while ready, with low byte 0x07, sets the row to bits 19:8 and the column to bits 31:20 from the next cycle. It produces no strobe and leaves ready at 1.
- R7: A data-register store while ready is 0 is discarded: no strobe and no cursor change. It sets the overrun flag.
- R8: A control-register store with bit 1 = 1 clears the overrun flag. Bit 1 = 0 leaves the flag unchanged, and all other bits of the word are ignored.
- R9: A read of the data register returns {column[11:0], row[11:0], 8'h07} for the current cursor.
- R10: A bus access with `bus_sel` low, or to any other address, changes no state and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, combinational from address |
| draw_stb | output | 1 | One-cycle character draw strobe |
| draw_char | output | 8 | Character code to draw |
| draw_row | output | 12 | Row of the drawn character |
| draw_col | output | 12 | Column of the drawn character |

## Verification
Read data is combinational, so register loads are sampled one time step after the address is set, with no clock edge in between. Every store is driven at a falling edge and captured on the next rising edge. The bench therefore looks for the draw strobe, the new cursor and the overrun flag at the falling edge right after that rising edge. The busy window is checked at each of the following DRAW_LAT falling edges: ready must read 0 at the first DRAW_LAT of them and 1 at the edge after. The checks sweep every printable code with a small line width, so that many row wraps occur. They also exercise a row overflow, a cursor column set beyond the line width, and back-to-back stores that land inside the busy window.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
   localparam int unsigned POS_W     = 12;
   localparam logic [7:0]  BELL_CODE = 8'h07;

   typedef enum logic [2:0] {
      ACC_IDLE,
      ACC_CTRL_WR,
      ACC_PRINT,
      ACC_CURSOR,
      ACC_DROP
   } acc_kind_e;

   typedef struct packed {
      logic [POS_W-1:0] col;
      logic [POS_W-1:0] row;
      logic [7:0]       code;
   } data_word_t;
endpackage

// File: rtl/tdp_regdec.sv
module tdp_regdec
   import tdp_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hFFFF0008
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              ready,
   output acc_kind_e         acc_kind,
   output logic              ovr_clr,
   output logic              rd_ctrl,
   output logic              rd_data
);
   localparam logic [ADDR_W-1:0] DATA_ADDR = CTRL_ADDR + ADDR_W'(4);

   if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_aw
      $error("tdp_regdec: ADDR_W must be 3..32");
   end
   if (CTRL_ADDR[1:0] != 2'b00) begin : g_bad_align
      $error("tdp_regdec: CTRL_ADDR must be word aligned");
   end

   logic       hit_ctrl, hit_data;
   data_word_t word;

   assign word     = data_word_t'(bus_wdata);
   assign hit_ctrl = bus_sel && (bus_addr == CTRL_ADDR);
   assign hit_data = bus_sel && (bus_addr == DATA_ADDR);

   always_comb begin
      acc_kind = ACC_IDLE;
      if (bus_wr) begin
         if (hit_ctrl)                    acc_kind = ACC_CTRL_WR;
         else if (hit_data && !ready)     acc_kind = ACC_DROP;
         else if (hit_data && word.code == BELL_CODE) acc_kind = ACC_CURSOR;
         else if (hit_data)               acc_kind = ACC_PRINT;
      end
   end

   assign ovr_clr = (acc_kind == ACC_CTRL_WR) && bus_wdata[1];
   assign rd_ctrl = hit_ctrl && !bus_wr;
   assign rd_data = hit_data && !bus_wr;
endmodule

// File: rtl/tdp_busy.sv
module tdp_busy #(
   parameter int unsigned DRAW_LAT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ready
);
   localparam int unsigned CNT_W = $clog2(DRAW_LAT + 1);

   if (DRAW_LAT < 1) begin : g_bad_lat
      $error("tdp_busy: DRAW_LAT must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt <= '0;
      else if (start)     cnt <= CNT_W'(DRAW_LAT);
      else if (cnt != '0) cnt <= cnt - CNT_W'(1);
   end

   assign ready = (cnt == '0);

   // R4: a start is only ever issued while idle
   a_r4_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ready);
   // R4: busy begins on the cycle after acceptance
   a_r4_busy_after: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !ready);
   // R4: busy ends after the last count
   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(1)) && !start |=> ready);
endmodule

// File: rtl/tdp_cursor.sv
module tdp_cursor #(
   parameter int unsigned LINE_W = 80,
   parameter int unsigned POS_W  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [POS_W-1:0] load_row,
   input  logic [POS_W-1:0] load_col,
   input  logic             advance,
   output logic [POS_W-1:0] row,
   output logic [POS_W-1:0] col
);
   localparam int unsigned MAX_COLS = 1 << POS_W;

   if (LINE_W < 1 || LINE_W > MAX_COLS) begin : g_bad_lw
      $error("tdp_cursor: LINE_W out of range");
   end

   logic at_end;

   if (LINE_W == MAX_COLS) begin : g_full_line
      assign at_end = &col;
   end else begin : g_short_line
      assign at_end = (col >= POS_W'(LINE_W - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row <= '0;
         col <= '0;
      end else if (load) begin
         row <= load_row;
         col <= load_col;
      end else if (advance) begin
         if (at_end) begin
            col <= '0;
            row <= row + POS_W'(1);
         end else begin
            col <= col + POS_W'(1);
         end
      end
   end

   // R6: a cursor command is never combined with an advance
   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !advance);
   // R6: command coordinates take effect on the next cycle
   a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (row == $past(load_row)) && (col == $past(load_col)));
   // R5: step within a line
   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !load && !at_end |=> (col == $past(col) + POS_W'(1)) && $stable(row));
   // R5: wrap to the start of the next row
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !load && at_end |=> (col == '0) && (row == $past(row) + POS_W'(1)));
endmodule

// File: rtl/text_display_port.sv
module text_display_port
   import tdp_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hFFFF0008,
   parameter int unsigned       DRAW_LAT  = 4,
   parameter int unsigned       LINE_W    = 80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              draw_stb,
   output logic [7:0]        draw_char,
   output logic [11:0]       draw_row,
   output logic [11:0]       draw_col
);
   localparam logic [ADDR_W-1:0] DATA_ADDR = CTRL_ADDR + ADDR_W'(4);

   acc_kind_e        acc_kind;
   logic             ovr_clr, rd_ctrl, rd_data;
   logic             ready, start, load;
   logic [POS_W-1:0] cur_row, cur_col;
   logic             ovr_q;
   data_word_t       word, rd_word;

   assign word = data_word_t'(bus_wdata);

   tdp_regdec #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regdec (
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .ready     (ready),
      .acc_kind  (acc_kind),
      .ovr_clr   (ovr_clr),
      .rd_ctrl   (rd_ctrl),
      .rd_data   (rd_data)
   );

   assign start = (acc_kind == ACC_PRINT);
   assign load  = (acc_kind == ACC_CURSOR);

   tdp_busy #(.DRAW_LAT(DRAW_LAT)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .ready (ready)
   );

   tdp_cursor #(.LINE_W(LINE_W), .POS_W(POS_W)) u_cursor (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_row (word.row),
      .load_col (word.col),
      .advance  (start),
      .row      (cur_row),
      .col      (cur_col)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                    ovr_q <= 1'b0;
      else if (acc_kind == ACC_DROP) ovr_q <= 1'b1;
      else if (ovr_clr)              ovr_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         draw_stb  <= 1'b0;
         draw_char <= '0;
         draw_row  <= '0;
         draw_col  <= '0;
      end else begin
         draw_stb <= start;
         if (start) begin
            draw_char <= word.code;
            draw_row  <= cur_row;
            draw_col  <= cur_col;
         end
      end
   end

   assign rd_word = '{col: cur_col, row: cur_row, code: BELL_CODE};

   always_comb begin
      bus_rdata = '0;
      if (rd_ctrl)      bus_rdata = {30'b0, ovr_q, ready};
      else if (rd_data) bus_rdata = rd_word;
   end

   // R3: the draw strobe lasts one cycle
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      draw_stb |=> !draw_stb);
   // R3: strobe position is the cursor before the advance
   a_r3_position: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> draw_stb && (draw_row == $past(cur_row)) && (draw_col == $past(cur_col)));
   // R7: a store into a busy port is discarded and flagged
   a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && bus_wr && (bus_addr == DATA_ADDR) && !ready
      |=> !draw_stb && ovr_q && $stable(cur_row) && $stable(cur_col));
   // R8: clearing the sticky flag
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && bus_wr && (bus_addr == CTRL_ADDR) && bus_wdata[1] |=> !ovr_q);
   // R6: a cursor command does not start the busy window
   a_r6_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ready && !draw_stb);
endmodule

// File: tb/text_display_port_tb.sv
module text_display_port_tb;
   localparam int          LAT  = 3;
   localparam int          LW   = 5;
   localparam logic [31:0] CTRL = 32'hFFFF0008;
   localparam logic [31:0] DATA = 32'hFFFF000C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic        draw_stb;
   logic [7:0]  draw_char;
   logic [11:0] draw_row, draw_col;

   int n_chk = 0, n_fail = 0;
   int mrow = 0, mcol = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   text_display_port #(.DRAW_LAT(LAT), .LINE_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .draw_stb(draw_stb), .draw_char(draw_char),
      .draw_row(draw_row), .draw_col(draw_col)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [31:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic wr_cyc(input logic s, input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = s; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   function automatic logic [31:0] cur_word();
      return {mcol[11:0], mrow[11:0], 8'h07};
   endfunction

   task automatic model_adv();
      if (mcol + 1 >= LW) begin mcol = 0; mrow = (mrow + 1) % 4096; end
      else mcol = mcol + 1;
   endtask

   task automatic print_one(input logic [7:0] c, input logic [23:0] junk);
      logic [31:0] d;
      wr_cyc(1'b1, DATA, {junk, c});
      chk("R3 strobe", {31'b0, draw_stb}, 32'd1);
      chk("R3 char", {24'b0, draw_char}, {24'b0, c});
      chk("R3 row", {20'b0, draw_row}, mrow[31:0]);
      chk("R3 col", {20'b0, draw_col}, mcol[31:0]);
      model_adv();
      rd(CTRL, d); chk("R4 busy first", d, 32'd0);
      for (int k = 1; k < LAT; k++) begin
         @(negedge clk);
         chk("R3 strobe low", {31'b0, draw_stb}, 32'd0);
         rd(CTRL, d); chk("R4 busy", d, 32'd0);
      end
      @(negedge clk);
      rd(CTRL, d); chk("R4 ready back", d, 32'd1);
      rd(DATA, d); chk("R5 cursor", d, cur_word());
   endtask

   task automatic cursor_cmd(input int r, input int c);
      logic [31:0] d;
      wr_cyc(1'b1, DATA, {c[11:0], r[11:0], 8'h07});
      mrow = r; mcol = c;
      chk("R6 no strobe", {31'b0, draw_stb}, 32'd0);
      rd(CTRL, d); chk("R6 ready kept", d, 32'd1);
      rd(DATA, d); chk("R6 cursor set", d, cur_word());
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 and R2: reset state through the control register
      rd(CTRL, d); chk("R1 R2 ctrl", d, 32'd1);
      rd(DATA, d); chk("R1 R9 cursor", d, 32'h0000_0007);
      chk("R1 strobe", {31'b0, draw_stb}, 32'd0);

      // R6 / R9 cursor command
      cursor_cmd(3, 2);

      // R3 R4 R5: sweep every printable code, junk in upper bits
      for (int c = 0; c < 256; c++) begin
         if (c != 7) print_one(c[7:0], 24'(c * 40503 + 17));
      end

      // R5: row overflow and a column beyond the line width
      cursor_cmd(4095, LW - 1);
      print_one(8'h41, 24'hFFFFFF);
      chk("R5 row wrap", {mrow[11:0], mcol[11:0]}, 24'h0);
      cursor_cmd(2, 100);
      print_one(8'h42, 24'h0);
      chk("R5 beyond width", mrow[31:0], 32'd3);

      // R7: stores landing inside the busy window
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = DATA; bus_wdata = 32'h0000_0043;
      @(negedge clk);
      chk("R7 first accepted", {31'b0, draw_stb}, 32'd1);
      model_adv();
      bus_wdata = 32'h0000_0044;
      @(negedge clk);
      bus_wdata = {12'd9, 12'd9, 8'h07};
      chk("R7 dropped char", {31'b0, draw_stb}, 32'd0);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      chk("R7 dropped cmd", {31'b0, draw_stb}, 32'd0);
      rd(CTRL, d); chk("R7 overrun set", d, 32'd2);
      repeat (LAT) @(negedge clk);
      rd(CTRL, d); chk("R7 overrun sticky", d, 32'd3);
      rd(DATA, d); chk("R7 cursor kept", d, cur_word());

      // R8: clear semantics of the control register
      wr_cyc(1'b1, CTRL, 32'hFFFF_FFFD);
      rd(CTRL, d); chk("R8 bit1 zero keeps", d, 32'd3);
      wr_cyc(1'b1, CTRL, 32'h0000_0002);
      rd(CTRL, d); chk("R8 clear", d, 32'd1);

      // R10: deselected and unmapped accesses
      wr_cyc(1'b0, DATA, 32'h0000_0045);
      chk("R10 unselected", {31'b0, draw_stb}, 32'd0);
      wr_cyc(1'b1, 32'hFFFF_0010, 32'h0000_0046);
      chk("R10 other addr", {31'b0, draw_stb}, 32'd0);
      wr_cyc(1'b1, 32'hFFFF_0004, {12'd5, 12'd5, 8'h07});
      rd(DATA, d); chk("R10 cursor kept", d, cur_word());
      rd(CTRL, d); chk("R10 ctrl kept", d, 32'd1);
      rd(32'hFFFF_0010, d); chk("R10 read other", d, 32'd0);

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule